// File: doc/BRIEF.md
# Configuration File Header Parser

This block reads a tagged configuration file one byte at a time and walks the header that comes before the raw configuration data. Each header section is made of a key byte, a big-endian length and that many payload bytes. The parser checks the fixed opening of the header and captures the four text fields (design name, target part, build date, build time) into fixed-size buffers. It then reads the 32-bit count of configuration bytes that follows.

After the header, the parser passes exactly that many configuration bytes downstream, one per handshake, and honours backpressure from the consumer. It also checks whether the first eight forwarded bytes form the expected synchronisation pattern. Compressed and uncompressed configuration data use the same container, so the parser treats them alike; only the byte count changes. A malformed header stops the parser with an error flag until the next reset. A fully forwarded payload raises a done flag.

Top module: `cfg_header_parser`

## Requirements
- R1: After reset, `done`, `error`, `syncOk`, `outValid` and all bits of `truncFlags`, `payloadLen` and the four text outputs are 0. `inReady` is 1.
- R2: The stream opens with a 2-byte big-endian length that must equal PRE_LEN (default 9). That many bytes are then skipped. Next comes a 2-byte length that must equal 1. Any other value in either length makes `error` go high.
- R3: Key bytes must arrive in this order: 0x61 before the name, 0x62 before the part, 0x63 before the date, 0x64 before the time, 0x65 before the payload length. A wrong key makes `error` go high. `error` stays high and `inReady` stays low until reset, and `done` never rises.
- R4: Each text field is a 2-byte big-endian length followed by that many bytes, including the trailing 0x00. Byte i of a field appears on bits [8i+7:8i] of its output for i < STR_BYTES. Bytes that were never written read as 0.
- R5: A text field whose length exceeds STR_BYTES keeps its first STR_BYTES bytes. It also sets its bit of `truncFlags`: bit 0 for name, 1 for part, 2 for date, 3 for time.
- R6: The 4 bytes after key 0x65 form a big-endian count that appears on `payloadLen` and holds once `done` is high.
- R7: Exactly `payloadLen` bytes after the count are forwarded in order on `outData`. `outValid` is high only while payload bytes are being passed.
- R8: While `outValid` is high and `outReady` is low, `inReady` is low, so no byte is lost or consumed.
- R9: `done` rises after the last payload byte is taken, or directly after the count when it is 0. `done` then stays high and `inReady` stays low.
- R10: `syncOk` rises once eight payload bytes have passed, if they were FF FF FF FF AA 99 55 66 in that order. It then stays high. Otherwise it stays 0.
- R11: A text field with length 0 has no body. Its output stays 0, and the next key byte follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Incoming file byte |
| inValid | input | 1 | Incoming byte present |
| inReady | output | 1 | Parser takes the byte this cycle |
| outData | output | 8 | Forwarded configuration byte |
| outValid | output | 1 | Forwarded byte present |
| outReady | input | 1 | Consumer takes the forwarded byte |
| designName | output | STR_BYTES*8 | Captured design name, byte 0 lowest |
| partName | output | STR_BYTES*8 | Captured part name |
| dateText | output | STR_BYTES*8 | Captured build date |
| timeText | output | STR_BYTES*8 | Captured build time |
| truncFlags | output | 4 | Per-field truncation bits |
| payloadLen | output | 32 | Declared payload byte count |
| syncOk | output | 1 | Sync pattern seen at payload start |
| done | output | 1 | Payload fully forwarded |
| error | output | 1 | Header fault, sticky |

## Verification
The bench builds the parser with STR_BYTES set to 8 and keeps PRE_LEN at 9. The small buffer means text fields of 9 to 12 bytes exercise truncation, and fields of exactly 8 bytes exercise the no-truncation edge, both within short random streams. The default preamble length keeps the length check at its normal value while bad-length streams test the fault path. A declared count of 0x01020304 checks the byte order of the 4-byte length without the bench having to send that many bytes.

// File: rtl/cfg_header_pkg.sv
package cfg_header_pkg;

  localparam int NUM_FIELDS = 4;
  localparam logic [7:0] KEY_BASE = 8'h61;
  localparam logic [63:0] SYNC_PATTERN = 64'hFFFF_FFFF_AA99_5566;

  typedef enum logic [3:0] {
    S_PRE_LEN,
    S_PRE_SKIP,
    S_A_LEN,
    S_KEY,
    S_STR_LEN,
    S_STR_BODY,
    S_PAY_LEN,
    S_PAYLOAD,
    S_DONE,
    S_ERR
  } parseState_t;

  typedef struct packed {
    logic lenFirst;   // start a new length accumulation
    logic lenShift;   // append a length byte
    logic loadCnt;    // load byte counter from assembled length
    logic decCnt;     // one counted byte consumed
    logic strWrite;   // store a text byte
    logic nextField;  // advance to next header field
    logic setTrunc;   // record truncation for current field
    logic latchPay;   // latch payload count
    logic payByte;    // one payload byte forwarded
  } cfgStrobe_t;

endpackage

// File: rtl/cfg_header_dpath.sv
module cfg_header_dpath
  import cfg_header_pkg::*;
#(
  parameter int STR_BYTES = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [7:0]                           inData,
  input  cfgStrobe_t                           strobe,
  output logic [31:0]                          lenNext,
  output logic                                 cntIsOne,
  output logic [2:0]                           fieldIdx,
  output logic [NUM_FIELDS*STR_BYTES*8-1:0]    strBufs,
  output logic [NUM_FIELDS-1:0]                truncFlags,
  output logic [31:0]                          payloadLen,
  output logic                                 syncOk
);

  localparam int POS_W = $clog2(STR_BYTES + 1);
  localparam int IDX_W = (STR_BYTES > 1) ? $clog2(STR_BYTES) : 1;

  logic [23:0]      lenReg;
  logic [31:0]      cnt;
  logic [POS_W-1:0] posCnt;
  logic [3:0]       payCnt;
  logic [55:0]      syncShift;
  logic             posInRange;

  assign lenNext    = {lenReg, inData};
  assign cntIsOne   = (cnt == 32'd1);
  assign posInRange = (posCnt < POS_W'(STR_BYTES));

  // Length accumulation, big-endian
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
    end else if (strobe.lenFirst) begin
      lenReg <= {16'h0, inData};
    end else if (strobe.lenShift) begin
      lenReg <= lenNext[23:0];
    end
  end

  // Remaining-byte counter and text write position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      posCnt <= '0;
    end else begin
      if (strobe.loadCnt) begin
        cnt    <= lenNext;
        posCnt <= '0;
      end else begin
        if (strobe.decCnt) cnt <= cnt - 32'd1;
        if (strobe.strWrite && posInRange) posCnt <= posCnt + POS_W'(1);
      end
    end
  end

  // Field sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldIdx <= '0;
    end else if (strobe.nextField) begin
      fieldIdx <= fieldIdx + 3'd1;
    end
  end

  // Per-field truncation flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      truncFlags <= '0;
    end else if (strobe.setTrunc && (fieldIdx < 3'(NUM_FIELDS))) begin
      truncFlags[fieldIdx[1:0]] <= (lenNext > 32'(STR_BYTES));
    end
  end

  // Text buffers, one per field
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [STR_BYTES-1:0][7:0] bufMem;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufMem <= '0;
      end else if (strobe.strWrite && posInRange && (fieldIdx == 3'(f))) begin
        bufMem[posCnt[IDX_W-1:0]] <= inData;
      end
    end

    assign strBufs[f*STR_BYTES*8 +: STR_BYTES*8] = bufMem;
  end

  // Payload count latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      payloadLen <= '0;
    end else if (strobe.latchPay) begin
      payloadLen <= lenNext;
    end
  end

  // Sync pattern check over the first eight payload bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      payCnt    <= '0;
      syncShift <= '0;
      syncOk    <= 1'b0;
    end else if (strobe.payByte && (payCnt < 4'd8)) begin
      payCnt    <= payCnt + 4'd1;
      syncShift <= {syncShift[47:0], inData};
      if ((payCnt == 4'd7) && ({syncShift, inData} == SYNC_PATTERN)) begin
        syncOk <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_header_ctrl.sv
module cfg_header_ctrl
  import cfg_header_pkg::*;
#(
  parameter int PRE_LEN = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inData,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  input  logic [31:0] lenNext,
  input  logic        cntIsOne,
  input  logic [2:0]  fieldIdx,
  output cfgStrobe_t  strobe,
  output logic        done,
  output logic        error
);

  localparam logic [31:0] PRE_LEN_V = 32'(PRE_LEN);
  localparam logic [31:0] KEY_A_LEN = 32'd1;

  parseState_t state, nxtState;
  logic [1:0]  lenIdx, nxtLenIdx;
  logic        acc, lenLast, isLenState, lenDone;
  logic [7:0]  expKey;

  assign expKey = KEY_BASE + {5'b0, fieldIdx};

  always_comb begin
    strobe    = '0;
    nxtState  = state;
    nxtLenIdx = lenIdx;

    if (state == S_PAYLOAD) inReady = outReady;
    else                    inReady = !((state == S_DONE) || (state == S_ERR));
    outValid = (state == S_PAYLOAD) && inValid;
    acc      = inValid && inReady;

    isLenState = (state == S_PRE_LEN) || (state == S_A_LEN) ||
                 (state == S_STR_LEN) || (state == S_PAY_LEN);
    lenLast    = (state == S_PAY_LEN) ? (lenIdx == 2'd3) : (lenIdx == 2'd1);
    lenDone    = acc && isLenState && lenLast;

    if (acc && isLenState && !lenLast) begin
      strobe.lenFirst = (lenIdx == 2'd0);
      strobe.lenShift = (lenIdx != 2'd0);
      nxtLenIdx       = lenIdx + 2'd1;
    end
    if (lenDone) nxtLenIdx = 2'd0;

    case (state)
      S_PRE_LEN: begin
        if (lenDone) begin
          if (lenNext == PRE_LEN_V) begin
            strobe.loadCnt = 1'b1;
            nxtState = (lenNext == 32'd0) ? S_A_LEN : S_PRE_SKIP;
          end else begin
            nxtState = S_ERR;
          end
        end
      end
      S_PRE_SKIP: begin
        if (acc) begin
          strobe.decCnt = 1'b1;
          if (cntIsOne) nxtState = S_A_LEN;
        end
      end
      S_A_LEN: begin
        if (lenDone) nxtState = (lenNext == KEY_A_LEN) ? S_KEY : S_ERR;
      end
      S_KEY: begin
        if (acc) begin
          if (inData != expKey) nxtState = S_ERR;
          else if (fieldIdx == 3'(NUM_FIELDS)) nxtState = S_PAY_LEN;
          else nxtState = S_STR_LEN;
        end
      end
      S_STR_LEN: begin
        if (lenDone) begin
          strobe.loadCnt  = 1'b1;
          strobe.setTrunc = 1'b1;
          if (lenNext == 32'd0) begin
            strobe.nextField = 1'b1;
            nxtState = S_KEY;
          end else begin
            nxtState = S_STR_BODY;
          end
        end
      end
      S_STR_BODY: begin
        if (acc) begin
          strobe.strWrite = 1'b1;
          strobe.decCnt   = 1'b1;
          if (cntIsOne) begin
            strobe.nextField = 1'b1;
            nxtState = S_KEY;
          end
        end
      end
      S_PAY_LEN: begin
        if (lenDone) begin
          strobe.loadCnt  = 1'b1;
          strobe.latchPay = 1'b1;
          nxtState = (lenNext == 32'd0) ? S_DONE : S_PAYLOAD;
        end
      end
      S_PAYLOAD: begin
        if (acc) begin
          strobe.payByte = 1'b1;
          strobe.decCnt  = 1'b1;
          if (cntIsOne) nxtState = S_DONE;
        end
      end
      default: nxtState = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_PRE_LEN;
      lenIdx <= 2'd0;
    end else begin
      state  <= nxtState;
      lenIdx <= nxtLenIdx;
    end
  end

  assign done  = (state == S_DONE);
  assign error = (state == S_ERR);

endmodule

// File: rtl/cfg_header_parser.sv
module cfg_header_parser
  import cfg_header_pkg::*;
#(
  parameter int STR_BYTES = 16,
  parameter int PRE_LEN   = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             inData,
  input  logic                   inValid,
  output logic                   inReady,
  output logic [7:0]             outData,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [STR_BYTES*8-1:0] designName,
  output logic [STR_BYTES*8-1:0] partName,
  output logic [STR_BYTES*8-1:0] dateText,
  output logic [STR_BYTES*8-1:0] timeText,
  output logic [3:0]             truncFlags,
  output logic [31:0]            payloadLen,
  output logic                   syncOk,
  output logic                   done,
  output logic                   error
);

  localparam int FW = STR_BYTES * 8;

  cfgStrobe_t                       strobe;
  logic [31:0]                      lenNext;
  logic                             cntIsOne;
  logic [2:0]                       fieldIdx;
  logic [NUM_FIELDS*FW-1:0]         strBufs;

  cfg_header_ctrl #(.PRE_LEN(PRE_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .lenNext  (lenNext),
    .cntIsOne (cntIsOne),
    .fieldIdx (fieldIdx),
    .strobe   (strobe),
    .done     (done),
    .error    (error)
  );

  cfg_header_dpath #(.STR_BYTES(STR_BYTES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .strobe     (strobe),
    .lenNext    (lenNext),
    .cntIsOne   (cntIsOne),
    .fieldIdx   (fieldIdx),
    .strBufs    (strBufs),
    .truncFlags (truncFlags),
    .payloadLen (payloadLen),
    .syncOk     (syncOk)
  );

  assign outData    = inData;
  assign designName = strBufs[0*FW +: FW];
  assign partName   = strBufs[1*FW +: FW];
  assign dateText   = strBufs[2*FW +: FW];
  assign timeText   = strBufs[3*FW +: FW];

endmodule

// File: rtl/cfg_header_parser_chk.sv
module cfg_header_parser_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic        done,
  input logic        error,
  input logic        syncOk,
  input logic [31:0] payloadLen
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) error |=> error); // R3
  AST_ERR_STALLS: assert property (@(posedge clk) disable iff (!rstN) error |-> !inReady); // R3
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(done && error)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN) done |=> done); // R9
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rstN) done |-> (!inReady && !outValid)); // R7
  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rstN) outValid |-> inValid); // R7
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outReady) |-> !inReady); // R8
  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rstN) syncOk |=> syncOk); // R10
  AST_PAYLEN_HOLD: assert property (@(posedge clk) disable iff (!rstN) done |=> $stable(payloadLen)); // R6

endmodule

bind cfg_header_parser cfg_header_parser_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .done       (done),
  .error      (error),
  .syncOk     (syncOk),
  .payloadLen (payloadLen)
);

// File: tb/cfg_header_parser_bench.sv
module cfg_header_parser_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SB = 8;
  localparam logic [63:0] SYNC = 64'hFFFF_FFFF_AA99_5566;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] outData;
  logic outValid;
  logic outReady = 1'b0;
  logic [SB*8-1:0] designName, partName, dateText, timeText;
  logic [3:0] truncFlags;
  logic [31:0] payloadLen;
  logic syncOk, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_header_parser #(.STR_BYTES(SB), .PRE_LEN(9)) u_cfg_header_parser (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .designName(designName), .partName(partName), .dateText(dateText), .timeText(timeText),
    .truncFlags(truncFlags), .payloadLen(payloadLen), .syncOk(syncOk), .done(done), .error(error)
  );

  int total = 0;
  int bad = 0;

  logic [7:0] fieldBytes [4][32];
  int         fieldLen   [4];
  logic [7:0] payBytes   [512];
  int         payLen;
  logic [7:0] streamBytes[1024];
  int         streamLen;
  logic [7:0] rxBytes    [512];
  int         rxCnt;
  int         bpErr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  function automatic logic [SB*8-1:0] expStr(input int k);
    logic [SB*8-1:0] v = '0;
    for (int i = 0; i < SB; i++)
      if (i < fieldLen[k]) v[8*i +: 8] = fieldBytes[k][i];
    return v;
  endfunction

  function automatic bit expSync();
    logic [63:0] v = '0;
    if (payLen < 8) return 1'b0;
    for (int i = 0; i < 8; i++) v = {v[55:0], payBytes[i]};
    return v == SYNC;
  endfunction

  task automatic push(input logic [7:0] b);
    streamBytes[streamLen] = b;
    streamLen++;
  endtask

  task automatic fillField(input int k, input int len);
    fieldLen[k] = len;
    for (int i = 0; i < len; i++) fieldBytes[k][i] = 8'h20 + 8'($urandom % 90);
    if (len > 0) fieldBytes[k][len-1] = 8'h00;
  endtask

  task automatic fillPayload(input int len, input bit withSync);
    payLen = len;
    for (int i = 0; i < len; i++) payBytes[i] = 8'($urandom);
    if (withSync && len >= 8)
      for (int i = 0; i < 8; i++) payBytes[i] = SYNC[63-8*i -: 8];
  endtask

  // badKey: -1 none, else index 0..4 of key to corrupt
  task automatic buildStream(input int preLenVal, input int badKey, input logic [31:0] payDecl);
    streamLen = 0;
    push(8'(preLenVal >> 8)); push(8'(preLenVal));
    for (int i = 0; i < 9; i++) push(8'($urandom));
    push(8'h00); push(8'h01);
    for (int k = 0; k < 4; k++) begin
      push((badKey == k) ? 8'h7A : 8'h61 + 8'(k));
      push(8'(fieldLen[k] >> 8)); push(8'(fieldLen[k]));
      for (int i = 0; i < fieldLen[k]; i++) push(fieldBytes[k][i]);
    end
    push((badKey == 4) ? 8'h66 : 8'h65);
    push(payDecl[31:24]); push(payDecl[23:16]); push(payDecl[15:8]); push(payDecl[7:0]);
    for (int i = 0; i < payLen; i++) push(payBytes[i]);
  endtask

  task automatic doReset();
    inValid = 1'b0; outReady = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runStream(input int maxCycles);
    int idx = 0;
    int cyc = 0;
    rxCnt = 0; bpErr = 0;
    while (idx < streamLen && cyc < maxCycles) begin
      @(negedge clk);
      inValid  = ($urandom % 4) != 0;
      outReady = ($urandom % 4) != 0;
      inData   = streamBytes[idx];
      #1;
      if (outValid && !outReady && inReady) bpErr++;
      if (outValid && outReady) begin
        if (rxCnt < 512) rxBytes[rxCnt] = outData;
        rxCnt++;
      end
      if (inValid && inReady) idx++;
      cyc++;
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic checkGood(input string name, input bit expDone, input logic [31:0] expLen);
    int mism = 0;
    chk(done == expDone, "R9", {name, " done"}, 128'(done), 128'(expDone));
    chk(!error, "R3", {name, " error"}, 128'(error), 0);
    chk(designName == expStr(0), "R4", {name, " name"}, 128'(designName), 128'(expStr(0)));
    chk(partName == expStr(1), "R4", {name, " part"}, 128'(partName), 128'(expStr(1)));
    chk(dateText == expStr(2), "R4", {name, " date"}, 128'(dateText), 128'(expStr(2)));
    chk(timeText == expStr(3), "R4", {name, " time"}, 128'(timeText), 128'(expStr(3)));
    begin
      logic [3:0] et = '0;
      for (int k = 0; k < 4; k++) et[k] = fieldLen[k] > SB;
      chk(truncFlags == et, "R5", {name, " trunc"}, 128'(truncFlags), 128'(et));
    end
    chk(payloadLen == expLen, "R6", {name, " payloadLen"}, 128'(payloadLen), 128'(expLen));
    chk(rxCnt == payLen, "R7", {name, " payload count"}, 128'(rxCnt), 128'(payLen));
    for (int i = 0; i < payLen && i < rxCnt; i++) if (rxBytes[i] != payBytes[i]) mism++;
    chk(mism == 0, "R7", {name, " payload bytes"}, 128'(mism), 0);
    chk(syncOk == expSync(), "R10", {name, " syncOk"}, 128'(syncOk), 128'(expSync()));
    chk(bpErr == 0, "R8", {name, " backpressure"}, 128'(bpErr), 0);
    if (expDone) chk(!inReady, "R9", {name, " inReady after done"}, 128'(inReady), 0);
  endtask

  task automatic checkErr(input string tag, input string name);
    chk(error, tag, {name, " error"}, 128'(error), 1);
    chk(!done, tag, {name, " done"}, 128'(done), 0);
    chk(!inReady, "R3", {name, " inReady stalled"}, 128'(inReady), 0);
  endtask

  initial begin
    void'($urandom(32'd20011));
    doReset();

    // R1 reset state
    chk(!done && !error && !syncOk && !outValid, "R1", "flags after reset",
        {done, error, syncOk, outValid}, 0);
    chk(truncFlags == 0 && payloadLen == 0, "R1", "trunc/len after reset",
        {truncFlags, payloadLen}, 0);
    chk(designName == 0 && partName == 0 && dateText == 0 && timeText == 0, "R1",
        "text after reset", 128'(designName), 0);
    chk(inReady, "R1", "inReady after reset", 128'(inReady), 1);

    // Directed: typical header with sync
    fillField(0, 6); fillField(1, 8); fillField(2, 7); fillField(3, 5);
    fillPayload(20, 1);
    buildStream(9, -1, 32'd20);
    runStream(2000);
    checkGood("typical", 1'b1, 32'd20);

    // R11 zero-length field, R9 zero payload
    doReset();
    fillField(0, 3); fillField(1, 0); fillField(2, 4); fillField(3, 0);
    fillPayload(0, 0);
    buildStream(9, -1, 32'd0);
    runStream(2000);
    chk(partName == 0 && timeText == 0, "R11", "zero-length fields empty",
        {partName, timeText}, 0);
    checkGood("zero lengths", 1'b1, 32'd0);

    // R10 exactly 8 bytes, last sync byte wrong
    doReset();
    fillField(0, 2); fillField(1, 2); fillField(2, 2); fillField(3, 2);
    fillPayload(8, 1);
    payBytes[7] = 8'h67;
    buildStream(9, -1, 32'd8);
    runStream(2000);
    chk(!syncOk, "R10", "corrupt sync rejected", 128'(syncOk), 0);
    checkGood("bad sync", 1'b1, 32'd8);

    // R5 truncation edge: exactly SB and SB+1
    doReset();
    fillField(0, SB); fillField(1, SB + 1); fillField(2, 20); fillField(3, 1);
    fillPayload(12, 1);
    buildStream(9, -1, 32'd12);
    runStream(2000);
    chk(truncFlags == 4'b0110, "R5", "trunc edges", 128'(truncFlags), 128'(4'b0110));
    checkGood("trunc edge", 1'b1, 32'd12);

    // R6 large declared count, partial payload
    doReset();
    fillField(0, 3); fillField(1, 3); fillField(2, 3); fillField(3, 3);
    fillPayload(50, 1);
    buildStream(9, -1, 32'h0102_0304);
    runStream(3000);
    checkGood("big count", 1'b0, 32'h0102_0304);

    // R2 bad preamble length
    doReset();
    fillPayload(4, 0);
    buildStream(10, -1, 32'd4);
    runStream(200);
    checkErr("R2", "bad preamble length");

    // R3 wrong key before date
    doReset();
    fillField(0, 4); fillField(1, 4); fillField(2, 4); fillField(3, 4);
    buildStream(9, 2, 32'd4);
    runStream(400);
    checkErr("R3", "bad key c");
    chk(partName == expStr(1), "R4", "part kept before fault", 128'(partName), 128'(expStr(1)));

    // R3 wrong payload key
    doReset();
    buildStream(9, 4, 32'd4);
    runStream(400);
    checkErr("R3", "bad key e");

    // Random streams
    for (int t = 0; t < 20; t++) begin
      int pl;
      doReset();
      for (int k = 0; k < 4; k++) fillField(k, $urandom % 13);
      pl = $urandom % 41;
      fillPayload(pl, ($urandom % 2) == 1);
      buildStream(9, -1, 32'(pl));
      runStream(4000);
      checkGood($sformatf("random%0d", t), 1'b1, 32'(pl));
    end

    summary();
    $finish;
  end

endmodule